// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block models a 256-byte serial EEPROM on a two-wire bus. A master that moves the clock and data lines as plain levels drives it. The block samples both lines on its own system clock. It recognises START and STOP, counts the clocked bits with one tick counter, and drives one data-out bit back toward the bus. Read data, and the low acknowledge slots, leave the block on that bit.

A transaction opens with a command byte, and bit 0 of that byte selects the direction. After a write command the next byte sets the word address, and any bytes that follow are acknowledged and discarded, so the array behaves as read-only. After a read command the block shifts out the byte at the current address, MSB first, and advances the address by one after every byte. A read can therefore run past 255 and wrap to 0. The array contents are fixed when the block is built, from two parameters.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While reset is held, and at the first clock after it, `sda_out` is high (released) and `bit_err` is low.
- R2: Before any START, a rising SCL edge has no effect and `sda_out` stays high, whatever the data line carries.
- R3: After START, eight rising SCL edges with SDA held steady shift in the command, MSB first. On the ninth rising edge `sda_out` goes low, and it is released again on the next rising edge.
- R4: With command bit 0 clear (0xA0 is used), the next eight bits form the word address, MSB first. An acknowledge (low) follows on the rising edge after the eighth address bit.
- R5: With command bit 0 set (0xA1 is used), the byte at the current address goes out on `sda_out`, one bit per rising SCL edge, MSB first. Byte a holds (a*INIT_MUL + INIT_ADD) mod 256, with defaults 29 and 0x5A.
- R6: After every read byte an acknowledge slot drives `sda_out` low. The next byte comes from the address plus one, modulo 256.
- R7: Bytes written after the word address are acknowledged and have no effect. A following read returns the original contents from the address that was set.
- R8: An SDA change on the same sample as an SCL rise, while a transaction is open, raises `bit_err` for one clock. The bit is not counted.
- R9: SDA rising while SCL stays high (STOP) releases `sda_out` and returns the block to idle. SDA falling while SCL stays high (START) restarts the command count at any point.
- R10: A read that starts without a new address continues from the address where the last completed byte left it (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level from the master |
| sda_in | input | 1 | Bus data level from the master |
| sda_out | output | 1 | Data level driven by the slave (1 = released) |
| bit_err | output | 1 | One-cycle pulse on a data change at an SCL rise |

## Verification
Every result is a register loaded at the first system clock edge that sees the new SCL or SDA level. `sda_out` is therefore valid one edge after the bus change and holds until the next SCL rise or bus condition. The bench holds each bus level for four clocks and probes `sda_out` one nanosecond after the falling edge that ends the hold. That is more than two clocks after the edge that updated it and well before the next bus change. `bit_err` lives for one clock, so it is counted on falling edges and compared after the transaction.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int         AW       = 8,
  parameter logic [7:0] INIT_MUL = 8'd29,
  parameter logic [7:0] INIT_ADD = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out,
  output logic bit_err
);
  localparam int BW = 8;
  localparam int TW = $clog2(2 * BW + 2);
  localparam logic [TW-1:0] T_CMD  = TW'(BW + 1);
  localparam logic [TW-1:0] T_BYTE = TW'(2 * BW + 1);

  function automatic logic [BW-1:0] rom_byte(input logic [AW-1:0] a);
    return BW'(a) * INIT_MUL + INIT_ADD;
  endfunction

  logic scl_q, sda_q;
  logic [TW-1:0] tick;
  logic ack_pend, have_addr, rd_mode;
  logic [BW-1:0] addr, data;

  logic bus_cond, start_c, stop_c, active, scl_rise, bit_ok;
  logic [BW-1:0] addr_shift, addr_inc;

  assign bus_cond   = scl_q & scl_in & (sda_q ^ sda_in);
  assign start_c    = bus_cond & ~sda_in;
  assign stop_c     = bus_cond & sda_in;
  assign active     = (tick != '0) | ack_pend;
  assign scl_rise   = ~scl_q & scl_in;
  assign bit_ok     = (sda_q == sda_in);
  assign addr_shift = {addr[BW-2:0], sda_in};
  assign addr_inc   = BW'(addr[AW-1:0] + AW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      tick      <= '0;
      ack_pend  <= 1'b0;
      have_addr <= 1'b0;
      rd_mode   <= 1'b0;
      addr      <= '0;
      data      <= rom_byte('0);
      sda_out   <= 1'b1;
      bit_err   <= 1'b0;
    end else begin
      scl_q   <= scl_in;
      sda_q   <= sda_in;
      bit_err <= 1'b0;
      if (start_c) begin
        tick      <= TW'(1);
        ack_pend  <= 1'b0;
        have_addr <= 1'b0;
        rd_mode   <= 1'b0;
        sda_out   <= 1'b1;
        data      <= rom_byte(addr[AW-1:0]);
      end else if (stop_c) begin
        tick     <= '0;
        ack_pend <= 1'b0;
        sda_out  <= 1'b1;
        data     <= rom_byte(addr[AW-1:0]);
      end else if (active && scl_rise) begin
        if (ack_pend) begin
          sda_out  <= 1'b0;
          ack_pend <= 1'b0;
          if (tick == T_BYTE) tick <= T_CMD;
        end else if (!bit_ok) begin
          bit_err <= 1'b1;
        end else if (tick < T_CMD) begin
          sda_out <= 1'b1;
          tick    <= tick + TW'(1);
          if (tick == T_CMD - TW'(1)) begin
            rd_mode  <= sda_in;
            ack_pend <= 1'b1;
          end
        end else begin
          sda_out <= 1'b1;
          tick    <= tick + TW'(1);
          if (rd_mode) begin
            sda_out <= data[BW-1];
            data    <= {data[BW-2:0], 1'b0};
          end else if (!have_addr) begin
            addr <= addr_shift;
          end
          if (tick == T_BYTE - TW'(1)) begin
            ack_pend <= 1'b1;
            if (rd_mode) begin
              addr <= addr_inc;
              data <= rom_byte(addr_inc[AW-1:0]);
            end else if (!have_addr) begin
              have_addr <= 1'b1;
              data      <= rom_byte(addr_shift[AW-1:0]);
            end
          end
        end
      end
    end
  end
endmodule

module i2c_eeprom_slave_chk #(
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_in,
  input logic          sda_out,
  input logic          bit_err,
  input logic [TW-1:0] tick
);
  assert_reset_release_R1: assert property (@(posedge clk)
    !rst_n |=> sda_out && !bit_err);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_out |-> tick != '0);

  assert_low_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_out) |-> $past(scl_in) && !$past(scl_in, 2));

  assert_tick_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= TW'(17));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(scl_in) && !$past(scl_in, 2) && ($past(sda_in) != $past(sda_in, 2)));

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_in && $past(scl_in) && sda_in && !$past(sda_in) |=> sda_out);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
  .sda_out(sda_out), .bit_err(bit_err), .tick(tick)
);

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
  localparam int HOLD = 4;
  localparam logic [7:0] MUL = 8'd29;
  localparam logic [7:0] ADD = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0, scl_i = 1'b1, sda_i = 1'b1;
  logic sda_o, err_o;
  int checks = 0, fails = 0, err_cnt = 0;
  logic [7:0] cur = 8'h00;
  bit done = 0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t sb[$];
  event probe_ev;

  always #4 clk = ~clk;

  i2c_eeprom_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .sda_out(sda_o), .bit_err(err_o)
  );

  always @(negedge clk) if (rst_n && err_o === 1'b1) err_cnt++;

  function automatic logic [7:0] rom(input logic [7:0] a);
    return a * MUL + ADD;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial forever begin
    exp_t e;
    @(probe_ev);
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check(e.tag, int'(sda_o), int'(e.v));
    end
  end

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    scl_i = c;
    sda_i = d;
    repeat (HOLD - 1) @(negedge clk);
  endtask

  task automatic expect_out(input logic v, input string tag);
    #1;
    sb.push_back('{v, tag});
    ->probe_ev;
  endtask

  task automatic send_bit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ack_slot(input string tag);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    expect_out(1'b0, tag);
  endtask

  task automatic start_c();
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic stop_c();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    expect_out(1'b1, "R9");
  endtask

  task automatic set_addr(input logic [7:0] a);
    start_c();
    send_byte(8'hA0);
    ack_slot("R3");
    send_byte(a);
    ack_slot("R4");
    stop_c();
    cur = a;
  endtask

  task automatic read_cmd();
    start_c();
    send_byte(8'hA1);
    ack_slot("R3");
  endtask

  task automatic read_bytes(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = rom(cur);
      for (int i = 7; i >= 0; i--) begin
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        expect_out(v[i], tag);
      end
      ack_slot("R6");
      cur = cur + 8'd1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (5) @(negedge clk);
    check("R1", int'(sda_o), 1);
    check("R1", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sda_o), 1);

    for (int k = 0; k < 10; k++) begin
      send_bit(logic'(k % 2));
      expect_out(1'b1, "R2");
    end

    set_addr(8'h37);
    read_cmd();
    read_bytes(3, "R5");
    stop_c();

    read_cmd();
    read_bytes(2, "R10");
    stop_c();

    set_addr(8'hFE);
    read_cmd();
    read_bytes(3, "R6");
    stop_c();

    start_c();
    send_byte(8'hA0);
    ack_slot("R3");
    send_byte(8'h10);
    ack_slot("R4");
    send_byte(8'h00);
    ack_slot("R7");
    send_byte(8'hFF);
    ack_slot("R7");
    stop_c();
    cur = 8'h10;
    read_cmd();
    read_bytes(2, "R7");
    stop_c();

    e0 = err_cnt;
    start_c();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    ack_slot("R8");
    read_bytes(1, "R8");
    stop_c();
    check("R8", err_cnt - e0, 1);

    start_c();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_c();
    send_byte(8'hA1);
    ack_slot("R9");
    read_bytes(1, "R9");
    stop_c();
    for (int k = 0; k < 10; k++) begin
      send_bit(1'b0);
      expect_out(1'b1, "R9");
    end

    repeat (4) @(negedge clk);
    check("R8", int'(sb.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule